// File: doc/BRIEF.md
# JTAG Fast-Data Word Transfer Sequencer

This block is a host-side JTAG master that exchanges one 32-bit word with a target's fast-data register in one operation. A word is accepted on a valid/ready input. The block then generates TCK from the system clock through a programmable divider, and walks the target TAP from Run-Test/Idle into Shift-DR. It shifts a 33-bit DR scan and brings the TAP back to Run-Test/Idle. The first shifted position carries a processor-access handshake bit, driven as 0 on TDI. The 32 data bits follow, least significant first.

The TDO value captured in the handshake position reports whether the target was ready. When that value is 0, the whole header/scan/footer sequence is repeated at once with the same word. Repetition stops at a limit that is set per transfer. The result appears on a valid/ready output. It carries the received word, the last handshake value and an error flag. Back-pressure rules:
- `in_ready` is high only while the block is idle. A word is taken on a clock edge where `in_valid` and `in_ready` are both high.
- The result is held on the output, unchanged, until `out_ready` is seen high.
- No new word is accepted before the result has been taken.

Top module: `jfx_fastdata_seq`

## Requirements
- R1: After reset and between transfers, `jtag_tck` and `jtag_tms` are low, `in_ready` is high and `out_valid` is low.
- R2: `div_half` is latched when a word is accepted. Each TCK half-period then lasts `div_half`+1 system clocks, starting with a low half. `jtag_tms` and `jtag_tdi` change only in the cycle where TCK falls, or while TCK is low.
- R3: Every attempt opens with three TCK periods carrying TMS 1, 0, 0, with TDI 0.
- R4: The fourth period of an attempt is the handshake position, with TMS 0 and TDI 0. The next 32 periods drive the data word on TDI, bit 0 first. TMS is 0 in those periods except the one carrying bit 31, where it is 1.
- R5: Every attempt closes with two periods carrying TMS 1 then 0, with TDI 0. This leaves the target TAP in Run-Test/Idle.
- R6: TDO is sampled at each TCK rising edge. The value taken in the handshake period becomes `out_pracc`. The next 32 values form `out_data`, the first one landing in bit 0.
- R7: When the handshake value is 0 and the limit is not reached, the 38-period sequence restarts with the same word in the TCK period directly after the footer.
- R8: `max_retries` is latched at acceptance, and one transfer makes at most `max_retries`+1 attempts. If none returns handshake 1, the result has `out_err`=1 and `out_pracc`=0. Otherwise it has `out_err`=0 and `out_pracc`=1.
- R9: `out_valid` rises 2·38·A·(`div_half`+1) system clocks after the accepting edge, where A is the number of attempts. It stays high with `out_data`, `out_pracc` and `out_err` unchanged until a clock edge where `out_ready` is high.
- R10: `in_ready` is low from acceptance until the result is taken. While it is low, `in_valid` and `in_data` have no effect on the TAP pins or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_data | input | 32 | Word to shift into the target |
| div_half | input | 8 | TCK half-period minus one, in system clocks |
| max_retries | input | 4 | Extra attempts allowed after the first |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Word shifted out of the target |
| out_pracc | output | 1 | Last sampled handshake value |
| out_err | output | 1 | Attempt limit reached without handshake 1 |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data to target |
| jtag_tdo | input | 1 | Test data from target |

## Verification
The bench drives the pins into a behavioural TAP target that returns a chosen word. That target also withholds the handshake for a chosen number of scans, so a first-try success, a success after several retries and a limit exhaustion can be told apart by the attempt count and the error flag. Data patterns differ in their lowest and highest bits and are sent both ways: 0x12, all ones, and words with only the end bits set. A wrong shift direction, a dropped MSB-side TMS or an off-by-one scan length shows as a mismatch in the word the target received or in the returned word. The divider is varied between 0 and 3, so each TCK phase is checked at several lengths. A second word is offered throughout every transfer and the result is held under back-pressure, which separates a correct input gate from one that admits a word early.

// File: rtl/jfx_pkg.sv
package jfx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } jfx_state_e;

  localparam int unsigned HDR_SLOTS  = 3;
  localparam int unsigned ACC_SLOTS  = 1;
  localparam int unsigned FOOT_SLOTS = 2;

  function automatic int unsigned jfx_slot_count(input int unsigned data_w);
    return HDR_SLOTS + ACC_SLOTS + data_w + FOOT_SLOTS;
  endfunction
endpackage

// File: rtl/jfx_tck_div.sv
module jfx_tck_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tck,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap     = (cnt_q == div);
  assign rise_stb = run && !tck && wrap;
  assign fall_stb = run && tck && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      tck   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tck   <= ~tck;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  tck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tck);

  // R2
  tck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && tck != $past(tck)) |-> $past(cnt_q) == div);
endmodule

// File: rtl/jfx_tx_sel.sv
module jfx_tx_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SLOT_W = 6
) (
  input  logic              active,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] word,
  output logic              tms,
  output logic              tdi
);
  localparam logic [SLOT_W-1:0] DLAST_S = SLOT_W'(3 + DATA_W);
  localparam logic [SLOT_W-1:0] FOOT0_S = SLOT_W'(4 + DATA_W);

  logic [DATA_W-1:0] bit_sel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_sel
    assign bit_sel[i] = (slot == SLOT_W'(4 + i));
  end

  always_comb begin
    tms = active && ((slot == '0) || (slot == DLAST_S) || (slot == FOOT0_S));
    tdi = active && |(bit_sel & word);
  end
endmodule

// File: rtl/jfx_rx_capture.sv
module jfx_rx_capture #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_acc,
  input  logic              cap_data,
  input  logic              tdo,
  output logic              pracc,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pracc <= 1'b0;
      word  <= '0;
    end else begin
      if (cap_acc)  pracc <= tdo;
      if (cap_data) word  <= {tdo, word[DATA_W-1:1]};
    end
  end

  // R6
  acc_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_acc && cap_data));
endmodule

// File: rtl/jfx_fastdata_seq.sv
module jfx_fastdata_seq
  import jfx_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [DIV_W-1:0]   div_half,
  input  logic [RETRY_W-1:0] max_retries,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_pracc,
  output logic               out_err,
  output logic               jtag_tck,
  output logic               jtag_tms,
  output logic               jtag_tdi,
  input  logic               jtag_tdo
);
  localparam int unsigned NSLOT  = jfx_slot_count(DATA_W);
  localparam int unsigned SLOT_W = $clog2(NSLOT);
  localparam logic [SLOT_W-1:0] ACC_S   = SLOT_W'(HDR_SLOTS);
  localparam logic [SLOT_W-1:0] D0_S    = SLOT_W'(HDR_SLOTS + ACC_SLOTS);
  localparam logic [SLOT_W-1:0] DLAST_S = SLOT_W'(HDR_SLOTS + ACC_SLOTS + DATA_W - 1);
  localparam logic [SLOT_W-1:0] LAST_S  = SLOT_W'(NSLOT - 1);

  jfx_state_e         state_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [DATA_W-1:0]  word_q;
  logic [DIV_W-1:0]   div_q;
  logic [RETRY_W-1:0] lim_q;
  logic [RETRY_W-1:0] tries_q;
  logic               err_q;
  logic               run;
  logic               rise_stb;
  logic               fall_stb;
  logic               cap_acc;
  logic               cap_data;
  logic               pracc;

  assign run       = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign out_err   = err_q;
  assign out_pracc = pracc;
  assign cap_acc   = rise_stb && (slot_q == ACC_S);
  assign cap_data  = rise_stb && (slot_q >= D0_S) && (slot_q <= DLAST_S);

  jfx_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div      (div_q),
    .tck      (jtag_tck),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  jfx_tx_sel #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_tx (
    .active (run),
    .slot   (slot_q),
    .word   (word_q),
    .tms    (jtag_tms),
    .tdi    (jtag_tdi)
  );

  jfx_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_acc  (cap_acc),
    .cap_data (cap_data),
    .tdo      (jtag_tdo),
    .pracc    (pracc),
    .word     (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      word_q  <= '0;
      div_q   <= '0;
      lim_q   <= '0;
      tries_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            word_q  <= in_data;
            div_q   <= div_half;
            lim_q   <= max_retries;
            tries_q <= '0;
            slot_q  <= '0;
            err_q   <= 1'b0;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (rise_stb) state_q <= ST_HIGH;
        end
        ST_HIGH: begin
          if (fall_stb) begin
            if (slot_q == LAST_S) begin
              slot_q <= '0;
              if (pracc) begin
                state_q <= ST_DONE;
              end else if (tries_q == lim_q) begin
                err_q   <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                tries_q <= tries_q + 1'b1;
                state_q <= ST_LOW;
              end
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= ST_LOW;
            end
          end
        end
        ST_DONE: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  in_out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_err) && $stable(out_pracc)));

  // R2
  tms_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jtag_tms != $past(jtag_tms) || jtag_tdi != $past(jtag_tdi)) |-> !jtag_tck);

  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> !out_pracc);

  // R1
  done_tck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (!jtag_tck && !jtag_tms));

  // R8
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= lim_q);
endmodule

// File: tb/jfx_fastdata_seq_tb_top.sv
module jfx_fastdata_seq_tb_top;
  localparam int NSLOT = 38;
  localparam int T_RTI = 0, T_SEL = 1, T_CAP = 2, T_SH = 3, T_EX1 = 4, T_UPD = 5, T_OTH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [7:0]  div_half = '0;
  logic [3:0]  max_retries = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_pracc;
  logic        out_err;
  logic        jtag_tck, jtag_tms, jtag_tdi;
  logic        jtag_tdo = 1'b0;

  int checks = 0;
  int errors = 0;

  // behavioural TAP target
  int          tap = T_RTI;
  logic [32:0] tsr = '0;
  logic [32:0] rxv = '0;
  logic [32:0] last_rx = '0;
  int          rxn = 0;
  int          caps = 0;
  int          cap_base = 0;
  int          tgt_nak = 0;
  logic [31:0] tgt_resp = '0;

  always #5 clk = ~clk;

  jfx_fastdata_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .div_half(div_half), .max_retries(max_retries),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_pracc(out_pracc), .out_err(out_err), .jtag_tck(jtag_tck),
    .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_tdo(jtag_tdo)
  );

  always @(posedge jtag_tck) begin
    case (tap)
      T_RTI: tap = jtag_tms ? T_SEL : T_RTI;
      T_SEL: tap = jtag_tms ? T_OTH : T_CAP;
      T_CAP: begin
        tsr = {tgt_resp, ((caps - cap_base) >= tgt_nak)};
        rxn = 0;
        tap = jtag_tms ? T_EX1 : T_SH;
      end
      T_SH: begin
        if (rxn < 33) rxv[rxn] = jtag_tdi;
        rxn = rxn + 1;
        tsr = tsr >> 1;
        tap = jtag_tms ? T_EX1 : T_SH;
      end
      T_EX1: tap = jtag_tms ? T_UPD : T_OTH;
      T_UPD: begin
        last_rx = rxv;
        caps = caps + 1;
        tap = jtag_tms ? T_SEL : T_RTI;
      end
      default: tap = T_OTH;
    endcase
  end

  always @(negedge jtag_tck) jtag_tdo = (tap == T_SH) ? tsr[0] : 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_tms(input int slot);
    return (slot == 0) || (slot == 35) || (slot == 36);
  endfunction

  function automatic bit exp_tdi(input int slot, input logic [31:0] w);
    if (slot >= 4 && slot <= 35) return w[slot-4];
    return 1'b0;
  endfunction

  task automatic run_xfer(input logic [31:0] word, input logic [31:0] resp,
                          input int d, input int nak, input int lim);
    bit ok;
    int attempts, total, half, slot;
    logic [31:0] held;
    ok = (nak <= lim);
    attempts = ok ? nak + 1 : lim + 1;
    total = 2 * NSLOT * attempts * (d + 1);
    tgt_resp = resp;
    tgt_nak = nak;
    cap_base = caps;
    @(negedge clk);
    div_half = d[7:0];
    max_retries = lim[3:0];
    in_data = word;
    in_valid = 1'b1;
    check(in_ready == 1'b1, "R10", "in_ready idle", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_data = ~word;  // decoy offered during the busy phase (R10)
    for (int k = 0; k < total; k++) begin
      half = k / (d + 1);
      slot = (half / 2) % NSLOT;
      // R2 R3 R4 R5 R7 per-cycle pin comparison
      check(jtag_tck == half[0], "R2", "tck", jtag_tck, half[0]);
      check(jtag_tms == exp_tms(slot), "R3/R4/R5", "tms", jtag_tms, exp_tms(slot));
      check(jtag_tdi == exp_tdi(slot, word), "R4", "tdi", jtag_tdi, exp_tdi(slot, word));
      check(!out_valid && !in_ready, "R10", "busy flags", {out_valid, in_ready}, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9", "out_valid timing", out_valid, 1);
    check(jtag_tck == 1'b0, "R1", "tck low at done", jtag_tck, 0);
    check(out_data == resp, "R6", "out_data", out_data, resp);
    check(out_pracc == ok, "R8", "out_pracc", out_pracc, ok);
    check(out_err == !ok, "R8", "out_err", out_err, !ok);
    check(tap == T_RTI, "R5", "target TAP state", tap, T_RTI);
    check(caps - cap_base == attempts, "R7", "attempt count", caps - cap_base, attempts);
    check(last_rx == {word, 1'b0}, "R4", "word seen by target", last_rx, {word, 1'b0});
    held = out_data;
    repeat (3) begin
      @(negedge clk);
      check(out_valid && out_data == held, "R9", "held under back-pressure", out_data, held);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R1", "idle after take", {out_valid, in_ready}, 1);
    repeat (4) begin
      @(negedge clk);
      check(!jtag_tck && !jtag_tms, "R1", "pins quiet in idle", {jtag_tck, jtag_tms}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!jtag_tck && !jtag_tms && in_ready && !out_valid, "R1", "reset state",
          {jtag_tck, jtag_tms, in_ready, out_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    run_xfer(32'h0000_0012, 32'hCAFE_F00D, 0, 0, 0);
    run_xfer(32'hFFFF_FFFF, 32'h0000_0001, 1, 0, 2);
    run_xfer(32'h8000_0001, 32'h8000_0000, 3, 2, 3);
    run_xfer(32'hA5C3_0F96, 32'h1234_5678, 1, 5, 2);
    run_xfer(32'h0000_0000, 32'hFFFF_FFFF, 2, 1, 1);
    run_xfer(32'h7FFF_FFFE, 32'h0F0F_F0F0, 0, 0, 15);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule